// File: doc/BRIEF.md
# Video Line and Frame Timing Generator

This block turns the system clock into a stream of scanline start pulses and groups those lines into video frames. It supports a 60 Hz standard and a 50 Hz standard. Each has its own line count per frame and its own line period. The line period is not a whole number of clocks. It is held as a fixed-point value with 12 fractional bits and accumulated every clock, so the leftover fraction carries from one line to the next and across frame boundaries. The average line rate therefore does not drift.

Each line begins with a one-cycle line pulse, which a timer channel can count. When the line index reaches the blanking line, the block raises a one-cycle vertical-blank interrupt and holds an in-blanking level until the frame wraps. At the wrap the line index returns to zero, the frame counter advances and blanking ends. If interlace is enabled at that wrap, the field flag is loaded from the least significant bit of the new frame count. The standard-select input is sampled only at frame wraps, so a frame never changes length or line period partway through.

The reset is asserted asynchronously and must be released synchronously to `clk` by the chip's reset synchronizer.

Top module: `vtg_timing`

## Requirements
- R1: While `rst_n` is low, `hsync_tick`, `vblank_irq`, `in_vblank`, `field` and `frame_count` are all 0. The first frame after reset uses the 60 Hz standard (std_sel encoding 0).
- R2: `hsync_tick` is a single-cycle pulse. The gap between consecutive pulses is the floor or the ceiling of the active line period MULT/2^12 clocks, where MULT is MULT_60 when std_sel is 0 and MULT_50 when std_sel is 1.
- R3: A frame lasts LINES_60 line pulses under the 60 Hz standard and LINES_50 line pulses under the 50 Hz standard. The last of those pulses is the frame wrap.
- R4: `vblank_irq` pulses for one cycle, together with the line pulse that moves the line index to VBL_LINE. This is the VBL_LINE-th pulse after the frame's start. It is never high at any other time.
- R5: `in_vblank` rises with `vblank_irq` and stays high until the frame-wrap pulse, where it falls.
- R6: `frame_count` increases by exactly one at each frame-wrap pulse, wraps modulo 2^FRAME_W, and changes at no other time.
- R7: At each frame wrap, `field` is loaded with bit 0 of the new frame count if `ilace_en` is 1, and with 0 otherwise. It changes at no other time.
- R8: A change of `std_sel` affects neither the line count nor the line period of the current frame. It takes effect from the next frame wrap onward.
- R9: The fractional remainder carries between lines and across frames. Counting clock edges from reset release, under the 60 Hz standard the k-th line pulse is seen at edge ceil(k*MULT_60/2^12). Over any n whole lines of one standard where n*MULT is a multiple of 2^12, exactly n*MULT/2^12 clocks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| std_sel | input | 1 | Standard request: 0 = 60 Hz, 1 = 50 Hz; sampled at frame wrap |
| ilace_en | input | 1 | Interlace enable, sampled at frame wrap |
| hsync_tick | output | 1 | One-cycle pulse at the start of each line |
| vblank_irq | output | 1 | One-cycle pulse when blanking begins |
| in_vblank | output | 1 | High while the line index is in the blanking region |
| field | output | 1 | Interlace field flag |
| frame_count | output | FRAME_W | Number of completed frames, modulo 2^FRAME_W |

## Verification
The assertions check several properties on every cycle:
- Each line pulse lasts one cycle.
- The gap since the previous line pulse stays within the floor and ceiling bounds.
- The interrupt only appears together with a line pulse and the entry into blanking.
- Blanking only ends when the frame counter steps.
- The frame counter only moves by one on a line pulse.
- The field flag only changes at a frame step and, when set, matches the count's low bit.

The directed scenarios cover what needs a count over many lines:
- the exact line on which blanking starts and the exact line count per frame under each standard;
- the absolute pulse positions that show the fraction is carried rather than dropped;
- a standard change made mid-frame and deferred to the wrap;
- interlace being switched on and off;
- the frame counter rolling over.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Video standard selection, as latched at a frame boundary.
  typedef enum logic {
    STD_60 = 1'b0,
    STD_50 = 1'b1
  } vstd_e;

endpackage

// File: rtl/vtg_line_clock.sv
// Fractional line-period divider: adds one whole clock (2^FRAC_W) per cycle
// and subtracts the line period on each line boundary, keeping the remainder.
module vtg_line_clock
  import vtg_pkg::*;
#(
  parameter int unsigned FRAC_W  = 12,
  parameter int unsigned MULT_60 = 8791293,
  parameter int unsigned MULT_50 = 8836089,
  parameter int unsigned ACC_W   = 25
) (
  input  logic  clk,
  input  logic  rst_n,
  input  vstd_e std_q,
  output logic  line_wrap,
  output logic  tick_q
);

  localparam logic [ACC_W:0] ONE_CLK = (ACC_W+1)'(1) << FRAC_W;
  localparam logic [ACC_W:0] PER_60  = (ACC_W+1)'(MULT_60);
  localparam logic [ACC_W:0] PER_50  = (ACC_W+1)'(MULT_50);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum, period;

  // next-state
  always_comb begin
    period    = (std_q == STD_50) ? PER_50 : PER_60;
    sum       = {1'b0, acc_q} + ONE_CLK;
    line_wrap = (sum >= period);
    if (line_wrap) begin
      acc_d = ACC_W'(sum - period);
    end else begin
      acc_d = ACC_W'(sum);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= line_wrap;
    end
  end

endmodule

// File: rtl/vtg_frame_seq.sv
// Line/frame sequencer: line index, blanking window, frame count, field flag
// and the frame-boundary latch of the standard request.
module vtg_frame_seq
  import vtg_pkg::*;
#(
  parameter int unsigned LINES_60 = 263,
  parameter int unsigned LINES_50 = 314,
  parameter int unsigned VBL_LINE = 240,
  parameter int unsigned FRAME_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_wrap,
  input  vstd_e              std_req,
  input  logic               ilace_en,
  output vstd_e              std_q,
  output logic               vblank_irq_q,
  output logic               in_vblank_q,
  output logic               field_q,
  output logic [FRAME_W-1:0] frame_q
);

  localparam int unsigned LINES_MAX = (LINES_60 > LINES_50) ? LINES_60 : LINES_50;
  localparam int unsigned LINE_W    = $clog2(LINES_MAX);
  localparam logic [LINE_W-1:0] LAST_60 = LINE_W'(LINES_60 - 1);
  localparam logic [LINE_W-1:0] LAST_50 = LINE_W'(LINES_50 - 1);
  localparam logic [LINE_W-1:0] VBL_IDX = LINE_W'(VBL_LINE);

  logic [LINE_W-1:0]  line_q, line_d, line_inc;
  logic [FRAME_W-1:0] frame_d;
  vstd_e              std_d;
  logic               last_line, frame_end, blank_enter;
  logic               irq_d, in_vblank_d, field_d;

  // next-state
  always_comb begin
    line_inc    = line_q + 1'b1;
    last_line   = (line_q == ((std_q == STD_50) ? LAST_50 : LAST_60));
    frame_end   = line_wrap & last_line;
    blank_enter = line_wrap & ~last_line & (line_inc == VBL_IDX);

    line_d      = line_q;
    frame_d     = frame_q;
    field_d     = field_q;
    std_d       = std_q;
    in_vblank_d = in_vblank_q;
    irq_d       = blank_enter;

    if (line_wrap) begin
      line_d = last_line ? '0 : line_inc;
    end
    if (blank_enter) begin
      in_vblank_d = 1'b1;
    end
    if (frame_end) begin
      in_vblank_d = 1'b0;
      frame_d     = frame_q + 1'b1;
      field_d     = ilace_en & frame_d[0];
      std_d       = std_req;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q       <= '0;
      frame_q      <= '0;
      field_q      <= 1'b0;
      std_q        <= STD_60;
      in_vblank_q  <= 1'b0;
      vblank_irq_q <= 1'b0;
    end else begin
      line_q       <= line_d;
      frame_q      <= frame_d;
      field_q      <= field_d;
      std_q        <= std_d;
      in_vblank_q  <= in_vblank_d;
      vblank_irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/vtg_timing.sv
module vtg_timing
  import vtg_pkg::*;
#(
  parameter int unsigned FRAC_W   = 12,
  parameter int unsigned MULT_60  = 8791293,
  parameter int unsigned MULT_50  = 8836089,
  parameter int unsigned LINES_60 = 263,
  parameter int unsigned LINES_50 = 314,
  parameter int unsigned VBL_LINE = 240,
  parameter int unsigned FRAME_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               std_sel,
  input  logic               ilace_en,
  output logic               hsync_tick,
  output logic               vblank_irq,
  output logic               in_vblank,
  output logic               field,
  output logic [FRAME_W-1:0] frame_count
);

  localparam int unsigned MULT_MAX = (MULT_60 > MULT_50) ? MULT_60 : MULT_50;
  localparam int unsigned ACC_W    = $clog2(MULT_MAX) + 1;

  vstd_e std_req, std_q;
  logic  line_wrap;

  assign std_req = vstd_e'(std_sel);

  vtg_line_clock #(
    .FRAC_W (FRAC_W),
    .MULT_60(MULT_60),
    .MULT_50(MULT_50),
    .ACC_W  (ACC_W)
  ) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .std_q    (std_q),
    .line_wrap(line_wrap),
    .tick_q   (hsync_tick)
  );

  vtg_frame_seq #(
    .LINES_60(LINES_60),
    .LINES_50(LINES_50),
    .VBL_LINE(VBL_LINE),
    .FRAME_W (FRAME_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_wrap   (line_wrap),
    .std_req     (std_req),
    .ilace_en    (ilace_en),
    .std_q       (std_q),
    .vblank_irq_q(vblank_irq),
    .in_vblank_q (in_vblank),
    .field_q     (field),
    .frame_q     (frame_count)
  );

endmodule

// File: rtl/vtg_timing_chk.sv
module vtg_timing_chk #(
  parameter int unsigned FRAC_W  = 12,
  parameter int unsigned MULT_60 = 8791293,
  parameter int unsigned MULT_50 = 8836089,
  parameter int unsigned FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hsync_tick,
  input logic               vblank_irq,
  input logic               in_vblank,
  input logic               field,
  input logic [FRAME_W-1:0] frame_count
);

  localparam longint unsigned ONE_CLK = longint'(1) << FRAC_W;
  localparam longint unsigned P_MAX   = (MULT_60 > MULT_50) ? MULT_60 : MULT_50;
  localparam longint unsigned P_MIN   = (MULT_60 > MULT_50) ? MULT_50 : MULT_60;
  localparam int unsigned GAP_MAX = int'((P_MAX + ONE_CLK - 1) / ONE_CLK);
  localparam int unsigned GAP_MIN = int'(P_MIN / ONE_CLK);

  // consecutive cycles without a line pulse before the current cycle
  int unsigned low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= 0;
    end else if (hsync_tick) begin
      low_run_q <= 0;
    end else if (low_run_q < GAP_MAX + 4) begin
      low_run_q <= low_run_q + 1;
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_tick |=> !hsync_tick);

  a_r2_gap_max: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_tick |-> (low_run_q + 1 < GAP_MAX));

  a_r2_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_tick |-> (low_run_q + 1 >= GAP_MIN));

  a_r4_irq_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> (hsync_tick && in_vblank));

  a_r5_blank_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_vblank) |-> vblank_irq);

  a_r5_blank_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_vblank) |-> (hsync_tick && (frame_count != $past(frame_count))));

  a_r6_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_count != $past(frame_count)) |->
      (hsync_tick && (frame_count == FRAME_W'($past(frame_count) + 1'b1))));

  a_r7_field_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (field != $past(field)) |-> (frame_count != $past(frame_count)));

  a_r7_field_parity: assert property (@(posedge clk) disable iff (!rst_n)
    field |-> frame_count[0]);

endmodule

bind vtg_timing vtg_timing_chk #(
  .FRAC_W (FRAC_W),
  .MULT_60(MULT_60),
  .MULT_50(MULT_50),
  .FRAME_W(FRAME_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hsync_tick (hsync_tick),
  .vblank_irq (vblank_irq),
  .in_vblank  (in_vblank),
  .field      (field),
  .frame_count(frame_count)
);

// File: tb/tb_vtg_timing.sv
`timescale 1ns/1ps
module tb_vtg_timing;

  localparam int unsigned FRAC_W  = 12;
  localparam int unsigned MULT_60 = 41984;  // 10.25 clocks per line
  localparam int unsigned MULT_50 = 51200;  // 12.5 clocks per line
  localparam int unsigned L60     = 12;
  localparam int unsigned L50     = 15;
  localparam int unsigned VBL     = 8;
  localparam int unsigned FW      = 3;
  localparam longint ONE = longint'(1) << FRAC_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          std_sel;
  logic          ilace_en;
  logic          hsync_tick, vblank_irq, in_vblank, field;
  logic [FW-1:0] frame_count;

  vtg_timing #(
    .FRAC_W(FRAC_W), .MULT_60(MULT_60), .MULT_50(MULT_50),
    .LINES_60(L60), .LINES_50(L50), .VBL_LINE(VBL), .FRAME_W(FW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .ilace_en(ilace_en),
    .hsync_tick(hsync_tick), .vblank_irq(vblank_irq), .in_vblank(in_vblank),
    .field(field), .frame_count(frame_count)
  );

  always #10 clk = ~clk;  // 50 MHz

  longint cyc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int     n_cmp = 0;
  int     n_bad = 0;
  int     exp_frame, exp_field;
  longint last_wrap_cyc, tick_k;
  bit     abs_mode;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int grp_of(input longint p);
    for (int n = 1; n <= 16; n++) if (((n * p) % ONE) == 0) return n;
    return 0;
  endfunction

  task automatic wait_tick(output longint c);
    bit seen = 0;
    c = -1;
    for (int n = 0; n < 64 && !seen; n++) begin
      @(negedge clk);
      if (hsync_tick) begin seen = 1; c = cyc; end
    end
    if (!seen) chk("R2", "line pulse missing", 0, 1);
  endtask

  // Walks one frame of the given standard, optionally changing inputs after line act_line.
  task automatic run_frame(input bit fstd, input int act_line, input bit act_std, input bit act_il);
    int     lines = fstd ? L50 : L60;
    longint p     = fstd ? MULT_50 : MULT_60;
    longint lo    = p / ONE;
    longint hi    = (p + ONE - 1) / ONE;
    int     grp   = grp_of(p);
    longint tc[0:31];
    longint c;
    tc[0] = last_wrap_cyc;
    for (int i = 1; i <= lines; i++) begin
      wait_tick(c);
      tc[i] = c;
      chk("R2", "line gap within floor/ceil", ((c - tc[i-1]) >= lo && (c - tc[i-1]) <= hi), 1);
      if (grp > 0 && i >= grp) chk("R9", "whole-group clock count", c - tc[i-grp], grp * p / ONE);
      if (abs_mode) begin
        tick_k++;
        chk("R9", "absolute pulse edge", c, (tick_k * MULT_60 + ONE - 1) / ONE);
      end
      chk("R4", "vblank_irq on line", vblank_irq, (i == VBL));
      chk("R5", "in_vblank level", in_vblank, (i >= VBL && i < lines));
      if (i == lines) begin
        exp_frame = (exp_frame + 1) % (1 << FW);
        exp_field = ilace_en ? (exp_frame & 1) : 0;
        chk("R3", "frame advances on last line", frame_count, exp_frame);
        chk("R7", "field at wrap", field, exp_field);
        last_wrap_cyc = c;
      end else begin
        chk("R3", "frame holds mid-frame", frame_count, exp_frame);
        chk("R7", "field holds mid-frame", field, exp_field);
      end
      @(negedge clk);
      chk("R2", "pulse lasts one cycle", hsync_tick, 0);
      chk("R4", "irq lasts one cycle", vblank_irq, 0);
      if (i == act_line) begin
        std_sel  = act_std;
        ilace_en = act_il;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    std_sel = 1'b0;
    ilace_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "hsync_tick in reset", hsync_tick, 0);
    chk("R1", "vblank_irq in reset", vblank_irq, 0);
    chk("R1", "in_vblank in reset", in_vblank, 0);
    chk("R1", "field in reset", field, 0);
    chk("R1", "frame_count in reset", frame_count, 0);
    exp_frame = 0; exp_field = 0; last_wrap_cyc = 0; tick_k = 0; abs_mode = 1;
    rst_n = 1'b1;
  endtask

  // R1, R9: 60 Hz from reset, absolute pulse positions across a frame wrap
  task automatic t_absolute();
    run_frame(1'b0, -1, 1'b0, 1'b0);
    run_frame(1'b0, -1, 1'b0, 1'b0);
  endtask

  // R3, R8: standard request changed mid-frame takes effect at the wrap
  task automatic t_std_switch();
    abs_mode = 0;
    run_frame(1'b0, 3, 1'b1, 1'b0);   // still 60 Hz length and period
    run_frame(1'b1, -1, 1'b1, 1'b0);  // 50 Hz
    run_frame(1'b1, 5, 1'b0, 1'b0);   // still 50 Hz
    run_frame(1'b0, -1, 1'b0, 1'b0);  // back to 60 Hz
  endtask

  // R7: interlace on mid-frame, several fields, then off mid-frame
  task automatic t_interlace();
    run_frame(1'b0, 2, 1'b0, 1'b1);
    run_frame(1'b0, -1, 1'b0, 1'b1);
    run_frame(1'b0, -1, 1'b0, 1'b1);
    run_frame(1'b0, 4, 1'b0, 1'b0);
    chk("R7", "field cleared with interlace off", field, 0);
  endtask

  // R6: frame counter rolls over modulo 2^FW
  task automatic t_frame_wrap();
    int seen_zero = 0;
    for (int f = 0; f < (1 << FW); f++) begin
      run_frame(1'b0, -1, 1'b0, 1'b0);
      if (exp_frame == 0) begin
        seen_zero++;
        chk("R6", "rollover to zero", frame_count, 0);
      end
    end
    chk("R6", "rollover observed once", seen_zero, 1);
  endtask

  // R1: reset mid-frame returns everything to zero, then 60 Hz restarts
  task automatic t_mid_reset();
    longint c;
    std_sel = 1'b1;
    ilace_en = 1'b1;
    wait_tick(c);
    wait_tick(c);
    @(negedge clk);
    t_reset();
    run_frame(1'b0, -1, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_absolute();
    t_std_switch();
    t_interlace();
    t_frame_wrap();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule